// File: doc/BRIEF.md
# Stereo Automatic Gain Level Controller

This block produces one 7-bit gain code that a stereo input amplifier applies to both the left and the right channel. On every sample strobe it reads two post-gain level magnitudes and the polarity bit of each channel's sample. It decides on that strobe whether the shared gain should go down (limiting), go up toward a reference code (recovery), or stay where it is.

Limiting starts on the first strobe on which either channel's level is above the limit threshold. It keeps cutting the gain, one step per period, until no channel is above the threshold. The limiting steps after the first can be timed by a fixed period, or they can wait for a polarity change of either channel, with a timeout as a fallback. Once limiting is over, recovery raises the gain by one code per wait period. It counts only while at least one channel is below a lower recovery-reset level, and a level between the two thresholds clears its wait count. When the enable input is low, the block is in manual mode and passes a manual gain code through. Level filtering, register storage and the amplifier itself belong to the surrounding design.

Top module: `stereo_gain_leveler`

## Requirements
- R1: During reset, and after it, the gain output holds `refGain`. All timers are cleared and the controller starts in the idle (non-limiting) state.
- R2: While `agcEnable` is 0, `gainCode` equals the `manualGain` value of the previous clock. Strobes and levels have no effect, and the controller returns to idle with its timer cleared.
- R3: On a strobe where either `levelLeft` or `levelRight` is strictly greater than `limitLevel` and the controller is not limiting, the gain drops by 1 << `attenSel` (1, 2, 4 or 8) on that same strobe. A level equal to `limitLevel` is not over the limit.
- R4: With `zcGateEn` = 0 and a level still over the limit, a further attenuation step is applied every P strobes, where P = PERIOD_BASE << `limitPeriodSel`.
- R5: Attenuation saturates at code 0 and never wraps.
- R6: With `zcGateEn` = 1, each further limiting step waits for a zero crossing or a timeout. A zero crossing is a strobe whose `signLeft` or `signRight` (1 = negative) differs from its value on the previous strobe. The timeout is T = PERIOD_BASE << `zcTimeoutSel` strobes after the last step.
- R7: The first strobe with no level over the limit ends limiting and clears the timer. After that, each run of W = PERIOD_BASE << `waitSel` strobes with some level below `recoverResetLevel` raises the gain by 1. The gain never goes above `refGain`, and zero crossings do not shorten the wait.
- R8: A strobe with both levels below or at `limitLevel` and neither below `recoverResetLevel` clears the recovery wait timer and leaves the gain unchanged.
- R9: A level over the limit during recovery switches the block to limiting on that same strobe, with an immediate attenuation step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| agcEnable | input | 1 | 1 = automatic control, 0 = manual gain |
| sampleStrobe | input | 1 | One-cycle pulse marking a new sample |
| levelLeft | input | LEVEL_W | Left post-gain level magnitude |
| levelRight | input | LEVEL_W | Right post-gain level magnitude |
| signLeft | input | 1 | Left sample polarity, 1 = negative |
| signRight | input | 1 | Right sample polarity, 1 = negative |
| limitLevel | input | LEVEL_W | Limit threshold |
| recoverResetLevel | input | LEVEL_W | Level below which recovery counts |
| manualGain | input | GAIN_W | Gain used in manual mode |
| refGain | input | GAIN_W | Recovery target and reset gain |
| attenSel | input | 2 | Attenuation step select |
| limitPeriodSel | input | 2 | Limiting step period select |
| zcTimeoutSel | input | 2 | Zero-crossing timeout select |
| waitSel | input | 2 | Recovery wait period select |
| zcGateEn | input | 1 | Gate limiting steps on zero crossings |
| gainCode | output | GAIN_W | Shared gain code for both channels |

## Verification
The bench builds the block with PERIOD_BASE = 2, which shortens the four period choices to 2, 4, 8 and 16 strobes. With periods that short, a handful of strobes is enough to reach repeated limiting steps, zero-crossing timeouts and complete recovery waits. LEVEL_W = 8 keeps the threshold values small. It also lets the sequence walk the gain all the way down to code 0, and then clamp recovery against a reference of 1.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LIMIT   = 2'd1,
    ST_RECOVER = 2'd2
  } levelState_t;

  typedef struct packed {
    logic loadManual;
    logic attenStep;
    logic recoverStep;
  } gainCtl_t;

endpackage

// File: rtl/sgl_detect.sv
module sgl_detect #(
  parameter int LEVEL_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleStrobe,
  input  logic [LEVEL_W-1:0] levelLeft,
  input  logic [LEVEL_W-1:0] levelRight,
  input  logic               signLeft,
  input  logic               signRight,
  input  logic [LEVEL_W-1:0] limitLevel,
  input  logic [LEVEL_W-1:0] recoverResetLevel,
  output logic               overLimit,
  output logic               belowReset,
  output logic               zeroCross
);
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0][LEVEL_W-1:0] chanLevel;
  logic [NUM_CH-1:0]              chanSign;
  logic [NUM_CH-1:0]              prevSign;
  logic [NUM_CH-1:0]              chanOver;
  logic [NUM_CH-1:0]              chanLow;
  logic [NUM_CH-1:0]              chanFlip;
  logic                           signValid;

  assign chanLevel[0] = levelLeft;
  assign chanLevel[1] = levelRight;
  assign chanSign     = {signRight, signLeft};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    assign chanOver[ch] = chanLevel[ch] > limitLevel;
    assign chanLow[ch]  = chanLevel[ch] < recoverResetLevel;
    assign chanFlip[ch] = signValid && (chanSign[ch] != prevSign[ch]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSign  <= '0;
      signValid <= 1'b0;
    end else if (sampleStrobe) begin
      prevSign  <= chanSign;
      signValid <= 1'b1;
    end
  end

  assign overLimit  = |chanOver;
  assign belowReset = |chanLow;
  assign zeroCross  = |chanFlip;

  // Polarity history only moves on strobes (R6)
  assert_sign_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe && signValid |=> $stable(prevSign));

endmodule

// File: rtl/sgl_ctrl.sv
module sgl_ctrl
  import sgl_pkg::*;
#(
  parameter int PERIOD_BASE = 128,
  parameter int TIMER_W     = $clog2(PERIOD_BASE * 8 + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     agcEnable,
  input  logic     sampleStrobe,
  input  logic     overLimit,
  input  logic     belowReset,
  input  logic     zeroCross,
  input  logic     zcGateEn,
  input  logic [1:0] limitPeriodSel,
  input  logic [1:0] zcTimeoutSel,
  input  logic [1:0] waitSel,
  output gainCtl_t ctl
);
  localparam logic [TIMER_W-1:0] BASE_PER = TIMER_W'(PERIOD_BASE);
  localparam logic [TIMER_W-1:0] MAX_PER  = TIMER_W'(PERIOD_BASE * 8);

  levelState_t       state, stateNext;
  logic [TIMER_W-1:0] timer, timerNext, timerInc;
  logic [TIMER_W-1:0] limitPer, zcTimeoutPer, waitPer;
  logic              limitDue;

  assign limitPer     = BASE_PER << limitPeriodSel;
  assign zcTimeoutPer = BASE_PER << zcTimeoutSel;
  assign waitPer      = BASE_PER << waitSel;
  assign timerInc     = timer + 1'b1;
  assign limitDue     = zcGateEn ? (zeroCross || (timerInc >= zcTimeoutPer))
                                 : (timerInc >= limitPer);

  always_comb begin
    stateNext = state;
    timerNext = timer;
    ctl       = '0;
    if (!agcEnable) begin
      ctl.loadManual = 1'b1;
      stateNext      = ST_IDLE;
      timerNext      = '0;
    end else if (sampleStrobe) begin
      if (overLimit) begin
        if (state != ST_LIMIT) begin
          ctl.attenStep = 1'b1;
          stateNext     = ST_LIMIT;
          timerNext     = '0;
        end else if (limitDue) begin
          ctl.attenStep = 1'b1;
          timerNext     = '0;
        end else begin
          timerNext = timerInc;
        end
      end else if (state == ST_LIMIT) begin
        stateNext = ST_RECOVER;
        timerNext = '0;
      end else if (belowReset) begin
        if (timerInc >= waitPer) begin
          ctl.recoverStep = 1'b1;
          timerNext       = '0;
        end else begin
          timerNext = timerInc;
        end
      end else begin
        timerNext = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      state <= stateNext;
      timer <= timerNext;
    end
  end

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadManual, ctl.attenStep, ctl.recoverStep}));

  assert_manual_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !agcEnable |=> (state == ST_IDLE) && (timer == '0));

  assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    timer < MAX_PER);

  assert_band_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    agcEnable && sampleStrobe && !overLimit && !belowReset |=> timer == '0);

  assert_over_limits_R9: assert property (@(posedge clk) disable iff (!rstN)
    agcEnable && sampleStrobe && overLimit |=> state == ST_LIMIT);

endmodule

// File: rtl/sgl_gain_path.sv
module sgl_gain_path
  import sgl_pkg::*;
#(
  parameter int GAIN_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  gainCtl_t          ctl,
  input  logic [GAIN_W-1:0] manualGain,
  input  logic [GAIN_W-1:0] refGain,
  input  logic [1:0]        attenSel,
  output logic [GAIN_W-1:0] gainCode
);
  logic [GAIN_W-1:0] gainReg;
  logic [GAIN_W-1:0] stepSize;

  assign stepSize = GAIN_W'(1) << attenSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainReg <= refGain;
    end else if (ctl.loadManual) begin
      gainReg <= manualGain;
    end else if (ctl.attenStep) begin
      gainReg <= (gainReg > stepSize) ? (gainReg - stepSize) : '0;
    end else if (ctl.recoverStep && (gainReg < refGain)) begin
      gainReg <= gainReg + 1'b1;
    end
  end

  assign gainCode = gainReg;

  assert_atten_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.attenStep |=> gainReg <= $past(gainReg));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.attenStep && (gainReg <= stepSize) |=> gainReg == '0);

  assert_recover_clamp_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.recoverStep |=> (gainReg == $past(gainReg)) ||
      ((gainReg == $past(gainReg) + 1'b1) && (gainReg <= $past(refGain))));

endmodule

// File: rtl/stereo_gain_leveler.sv
module stereo_gain_leveler
  import sgl_pkg::*;
#(
  parameter int GAIN_W      = 7,
  parameter int LEVEL_W     = 16,
  parameter int PERIOD_BASE = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               agcEnable,
  input  logic               sampleStrobe,
  input  logic [LEVEL_W-1:0] levelLeft,
  input  logic [LEVEL_W-1:0] levelRight,
  input  logic               signLeft,
  input  logic               signRight,
  input  logic [LEVEL_W-1:0] limitLevel,
  input  logic [LEVEL_W-1:0] recoverResetLevel,
  input  logic [GAIN_W-1:0]  manualGain,
  input  logic [GAIN_W-1:0]  refGain,
  input  logic [1:0]         attenSel,
  input  logic [1:0]         limitPeriodSel,
  input  logic [1:0]         zcTimeoutSel,
  input  logic [1:0]         waitSel,
  input  logic               zcGateEn,
  output logic [GAIN_W-1:0]  gainCode
);
  localparam int TIMER_W = $clog2(PERIOD_BASE * 8 + 1);

  logic     overLimit, belowReset, zeroCross;
  gainCtl_t ctl;
  logic     outOfReset;

  sgl_detect #(.LEVEL_W(LEVEL_W)) u_detect (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe),
    .levelLeft(levelLeft), .levelRight(levelRight),
    .signLeft(signLeft), .signRight(signRight),
    .limitLevel(limitLevel), .recoverResetLevel(recoverResetLevel),
    .overLimit(overLimit), .belowReset(belowReset), .zeroCross(zeroCross)
  );

  sgl_ctrl #(.PERIOD_BASE(PERIOD_BASE), .TIMER_W(TIMER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .agcEnable(agcEnable), .sampleStrobe(sampleStrobe),
    .overLimit(overLimit), .belowReset(belowReset), .zeroCross(zeroCross),
    .zcGateEn(zcGateEn), .limitPeriodSel(limitPeriodSel),
    .zcTimeoutSel(zcTimeoutSel), .waitSel(waitSel), .ctl(ctl)
  );

  sgl_gain_path #(.GAIN_W(GAIN_W)) u_gain (
    .clk(clk), .rstN(rstN), .ctl(ctl), .manualGain(manualGain),
    .refGain(refGain), .attenSel(attenSel), .gainCode(gainCode)
  );

  always_ff @(posedge clk) begin
    if (!rstN) outOfReset <= 1'b0;
    else       outOfReset <= 1'b1;
  end

  assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    outOfReset && $past(!agcEnable) |-> gainCode == $past(manualGain));

  assert_reset_gain_R1: assert property (@(posedge clk)
    $past(!rstN) && !outOfReset && rstN |-> gainCode == $past(refGain));

endmodule

// File: tb/stereo_gain_leveler_tb.sv
module stereo_gain_leveler_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int GAIN_W      = 7;
  localparam int LEVEL_W     = 8;
  localparam int PERIOD_BASE = 2;

  logic               clk = 1'b0;
  logic               rstN, agcEnable, sampleStrobe, signLeft, signRight, zcGateEn;
  logic [LEVEL_W-1:0] levelLeft, levelRight, limitLevel, recoverResetLevel;
  logic [GAIN_W-1:0]  manualGain, refGain, gainCode;
  logic [1:0]         attenSel, limitPeriodSel, zcTimeoutSel, waitSel;

  typedef struct {
    int    expGain;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int testsRun    = 0;
  int testsFailed = 0;
  bit finished    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_gain_leveler #(.GAIN_W(GAIN_W), .LEVEL_W(LEVEL_W), .PERIOD_BASE(PERIOD_BASE)) u_dut (
    .clk(clk), .rstN(rstN), .agcEnable(agcEnable), .sampleStrobe(sampleStrobe),
    .levelLeft(levelLeft), .levelRight(levelRight),
    .signLeft(signLeft), .signRight(signRight),
    .limitLevel(limitLevel), .recoverResetLevel(recoverResetLevel),
    .manualGain(manualGain), .refGain(refGain), .attenSel(attenSel),
    .limitPeriodSel(limitPeriodSel), .zcTimeoutSel(zcTimeoutSel),
    .waitSel(waitSel), .zcGateEn(zcGateEn), .gainCode(gainCode)
  );

  task automatic compareGain(int expGain, string tag);
    testsRun++;
    if (gainCode !== GAIN_W'(expGain)) begin
      testsFailed++;
      $display("FAIL %s: gainCode=%0d expected=%0d", tag, gainCode, expGain);
    end
  endtask

  // Driver: one strobe, expected gain goes to the scoreboard
  task automatic strobe(int lvlL, int lvlR, bit negL, int expGain, string tag);
    expItem_t item;
    @(negedge clk);
    levelLeft    = LEVEL_W'(lvlL);
    levelRight   = LEVEL_W'(lvlR);
    signLeft     = negL;
    sampleStrobe = 1'b1;
    item.expGain = expGain;
    item.tag     = tag;
    expQ.push_back(item);
    @(negedge clk);
    sampleStrobe = 1'b0;
  endtask

  // Monitor: result of a strobe is visible after the edge that took it
  initial begin
    forever begin
      @(posedge clk);
      if (rstN === 1'b1 && sampleStrobe === 1'b1) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          testsRun++;
          testsFailed++;
          $display("FAIL scoreboard: gainCode=%0d expected=<queued item>", gainCode);
        end else begin
          expItem_t item;
          item = expQ.pop_front();
          compareGain(item.expGain, item.tag);
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: done=0 expected=1");
    finishRun();
  end

  initial begin
    rstN = 1'b0; agcEnable = 1'b1; sampleStrobe = 1'b0;
    levelLeft = '0; levelRight = '0; signLeft = 1'b0; signRight = 1'b0;
    limitLevel = 8'd100; recoverResetLevel = 8'd40;
    manualGain = 7'd0; refGain = 7'd60;
    attenSel = 2'd1; limitPeriodSel = 2'd0; zcTimeoutSel = 2'd1; waitSel = 2'd0;
    zcGateEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareGain(60, "R1 reset gain");
    @(negedge clk);
    compareGain(60, "R1 idle hold");

    // Manual mode
    agcEnable = 1'b0; manualGain = 7'd20;
    @(negedge clk);
    compareGain(20, "R2 manual follow");
    strobe(120, 120, 0, 20, "R2 loud ignored in manual");
    manualGain = 7'd50;
    @(negedge clk);
    compareGain(50, "R2 manual follow 2");
    agcEnable = 1'b1;

    // Band holds, equality not over, recovery steps
    strobe(50, 50, 0, 50, "R8 band hold");
    strobe(50, 50, 0, 50, "R8 band hold 2");
    strobe(100, 30, 0, 50, "R3 equal level not over");
    strobe(30, 30, 0, 51, "R7 recovery step");
    strobe(50, 50, 0, 51, "R8 band clears");
    strobe(30, 30, 0, 51, "R8 restart count");
    strobe(50, 50, 0, 51, "R8 band clears again");
    strobe(30, 30, 0, 51, "R8 restart count 2");
    strobe(30, 30, 0, 52, "R8 full wait step");

    // Limiting, fixed period
    strobe(30, 101, 0, 50, "R3 right channel over");
    strobe(101, 30, 0, 50, "R4 inside period");
    strobe(101, 30, 0, 48, "R4 period step");
    strobe(101, 30, 0, 48, "R4 inside period 2");
    strobe(101, 30, 0, 46, "R4 period step 2");

    // Recovery, zero crossing ignored
    strobe(30, 30, 0, 46, "R7 limit ends");
    strobe(30, 30, 0, 46, "R7 wait");
    strobe(30, 30, 0, 47, "R7 step");
    strobe(30, 30, 1, 47, "R7 zero cross no effect");
    strobe(30, 30, 0, 48, "R7 step after wait");

    // Recovery interrupted
    strobe(30, 30, 0, 48, "R9 counting");
    strobe(120, 30, 0, 46, "R9 immediate limit");

    // Zero-cross gated limiting
    zcGateEn = 1'b1;
    strobe(120, 120, 0, 46, "R6 no crossing");
    strobe(120, 120, 1, 44, "R6 crossing step");
    strobe(120, 120, 1, 44, "R6 wait 1");
    strobe(120, 120, 1, 44, "R6 wait 2");
    strobe(120, 120, 1, 44, "R6 wait 3");
    strobe(120, 120, 1, 42, "R6 timeout step");

    // Saturation at zero, step of 8
    attenSel = 2'd3;
    strobe(120, 120, 0, 34, "R5 big step");
    strobe(120, 120, 1, 26, "R5 big step 2");
    strobe(120, 120, 0, 18, "R5 big step 3");
    strobe(120, 120, 1, 10, "R5 big step 4");
    strobe(120, 120, 0, 2, "R5 big step 5");
    strobe(120, 120, 1, 0, "R5 saturate");
    strobe(120, 120, 0, 0, "R5 stay at zero");

    // Recovery clamp at reference
    refGain = 7'd1; zcGateEn = 1'b0;
    strobe(30, 30, 0, 0, "R7 leave limit");
    strobe(30, 30, 0, 0, "R7 wait at zero");
    strobe(30, 30, 0, 1, "R7 reach ref");
    strobe(30, 30, 0, 1, "R7 wait at ref");
    strobe(30, 30, 0, 1, "R7 clamp at ref");

    // Back to manual
    @(negedge clk);
    agcEnable = 1'b0; manualGain = 7'd33;
    @(negedge clk);
    compareGain(33, "R2 manual again");

    repeat (3) @(negedge clk);
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL scoreboard drain: left=%0d expected=0", expQ.size());
    end
    finishRun();
  end
endmodule